// File: doc/BRIEF.md
# Open-Row Memory Latency Model

This block is a synthesizable behavioural stand-in for a large dynamic memory that keeps one row open at a time. A client issues one request at a time over a valid/ready handshake. The request carries a byte address, a write flag, a burst flag, a burst length and write data. The model stores bytes in a small internal array. It does not mimic electrical timing. What it reproduces is the cost structure: staying inside the open row is cheap, moving to another row is expensive, and a block fetch pays a fixed setup plus one cycle per byte.

The address splits into a row index in the upper bits and a byte column in the lower bits. The controller has four states. `ST_IDLE` is ready. `ST_ACCESS` counts down the access latency. `ST_STREAM` returns one burst byte per cycle. `ST_REJECT` reports a refused request for one cycle. The transitions are:

- `ST_IDLE` goes to `ST_ACCESS` on an accepted legal request, or to `ST_REJECT` on an illegal burst.
- `ST_ACCESS` goes back to `ST_IDLE` when a single access ends, or to `ST_STREAM` when a burst's setup ends.
- `ST_STREAM` goes to `ST_IDLE` after the last byte.
- `ST_REJECT` always goes back to `ST_IDLE`.

A free-running busy-cycle counter lets a test compare total loop cost against its own count of hits and misses.

Top module: `olm_open_row_mem`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and rsp_err are 0, busy_cycles is 0, and no row is open.
- R2: A single access (req_burst=0) to a row other than the open one keeps the block busy (req_ready low) for exactly 10 cycles. The first access after reset is always such a miss.
- R3: A single access to the currently open row keeps the block busy for exactly 3 cycles.
- R4: The row index is req_addr[10:8] and the byte column is req_addr[7:0], so a row holds 256 bytes (128 16-bit words). Addresses 0x0FF and 0x000 share a row; 0x100 is a different row.
- R5: A read burst (req_burst=1, req_write=0) of n bytes, with req_len = n-1 and n from 1 to 256, is busy for 10+n cycles whether or not it hits. rsp_valid is high in exactly the last n busy cycles, and rsp_data carries the bytes at consecutive addresses starting at req_addr.
- R6: A burst whose last byte would fall past column 255 is refused. rsp_err is high for one busy cycle, no data is returned, memory is unchanged, and the open row is unchanged.
- R7: A burst with req_write=1 is refused in the same way as R6.
- R8: A single write stores req_wdata at req_addr and returns no rsp_valid. A single read returns the stored byte with rsp_valid high in its last busy cycle only.
- R9: While busy, req_ready is low and any request on the inputs is ignored; a write held during that time does not change memory.
- R10: busy_cycles rises by exactly one for every cycle in which req_ready is low, and holds otherwise.
- R11: An accepted burst opens its row, so a following single access to that row costs 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst read of req_len+1 bytes |
| req_addr | input | 11 | Byte address: row in upper bits, column in lower |
| req_len | input | 8 | Burst byte count minus one |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | rsp_data holds a read byte |
| rsp_data | output | 8 | Read byte |
| rsp_err | output | 1 | Request refused (one cycle) |
| busy_cycles | output | 32 | Total busy cycles since reset |

## Verification
The bench targets four corner cases:

- Row-boundary addresses: column 255 next to column 0 of the next row. A wrong split of the address would charge a hit where a miss is due.
- Bursts that end exactly on the last column, and bursts one byte past it. An off-by-one in the crossing test would either refuse a legal burst or stream bytes from the neighbouring row.
- Hits taken right after a refused burst and right after a burst. A design that updated or failed to update the open row on these requests would show 10 cycles where 3 are expected.
- A write held on the inputs through a busy period. A design that sampled requests while busy would corrupt the byte that is read back later.

Random traffic over four rows then compares every latency, every data byte and every counter step against a bench-side model of the open row.

// File: rtl/olm_pkg.sv
package olm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_STREAM = 2'd2,
        ST_REJECT = 2'd3
    } olm_state_e;

endpackage

// File: rtl/olm_cost_calc.sv
module olm_cost_calc #(
    parameter int ROW_W       = 3,
    parameter int COL_W       = 8,
    parameter int LAT_W       = 5,
    parameter int MISS_LAT    = 10,
    parameter int HIT_LAT     = 3,
    parameter int BURST_SETUP = 10
) (
    input  logic             burst,
    input  logic             write,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] len,
    input  logic             open_valid,
    input  logic [ROW_W-1:0] open_row,
    output logic             hit,
    output logic             reject,
    output logic [LAT_W-1:0] wait_load
);

    // Column of the last burst byte; a carry out means the burst leaves the row.
    logic [COL_W:0] last_col;

    assign last_col = {1'b0, col} + {1'b0, len};

    always_comb begin
        hit    = open_valid && (open_row == row);
        reject = burst && (write || last_col[COL_W]);
        if (burst) begin
            wait_load = LAT_W'(BURST_SETUP - 1);
        end else if (hit) begin
            wait_load = LAT_W'(HIT_LAT - 1);
        end else begin
            wait_load = LAT_W'(MISS_LAT - 1);
        end
    end

endmodule

// File: rtl/olm_row_tracker.sv
module olm_row_tracker #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row_in,
    output logic             open_valid,
    output logic [ROW_W-1:0] open_row
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (open_en) begin
            open_valid <= 1'b1;
            open_row   <= open_row_in;
        end
    end

    // R11: an opened row is the one tracked on the next cycle
    a_r11_row_opened: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |=> (open_valid && open_row == $past(open_row_in)));

    // R6: without an open request the tracked row never moves
    a_r6_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        !open_en |=> (open_row == $past(open_row) && open_valid == $past(open_valid)));

endmodule

// File: rtl/olm_byte_store.sv
module olm_byte_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/olm_open_row_mem.sv
module olm_open_row_mem
    import olm_pkg::*;
#(
    parameter int ROW_W       = 3,
    parameter int COL_W       = 8,
    parameter int DATA_W      = 8,
    parameter int MISS_LAT    = 10,
    parameter int HIT_LAT     = 3,
    parameter int BURST_SETUP = 10,
    parameter int CNT_W       = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic                   req_burst,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [COL_W-1:0]       req_len,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   rsp_err,
    output logic [CNT_W-1:0]       busy_cycles
);

    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int MAX_LAT = (MISS_LAT > BURST_SETUP) ? MISS_LAT : BURST_SETUP;
    localparam int LAT_W   = $clog2(MAX_LAT) + 1;

    olm_state_e        state, state_n;
    logic [LAT_W-1:0]  wait_cnt, wait_n;
    logic [COL_W-1:0]  left_cnt, left_n;
    logic [ADDR_W-1:0] ptr, ptr_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [DATA_W-1:0] wdata_q, wdata_n;
    logic [COL_W-1:0]  len_q, len_n;
    logic              write_q, write_n;
    logic              burst_q, burst_n;

    logic              accept;
    logic              hit;
    logic              reject;
    logic [LAT_W-1:0]  wait_load;
    logic              open_valid;
    logic [ROW_W-1:0]  open_row;
    logic              store_we;
    logic [ADDR_W-1:0] store_raddr;
    logic [DATA_W-1:0] store_rdata;

    olm_cost_calc #(
        .ROW_W       (ROW_W),
        .COL_W       (COL_W),
        .LAT_W       (LAT_W),
        .MISS_LAT    (MISS_LAT),
        .HIT_LAT     (HIT_LAT),
        .BURST_SETUP (BURST_SETUP)
    ) cost_i (
        .burst      (req_burst),
        .write      (req_write),
        .row        (req_addr[ADDR_W-1:COL_W]),
        .col        (req_addr[COL_W-1:0]),
        .len        (req_len),
        .open_valid (open_valid),
        .open_row   (open_row),
        .hit        (hit),
        .reject     (reject),
        .wait_load  (wait_load)
    );

    olm_row_tracker #(
        .ROW_W (ROW_W)
    ) rows_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_en     (accept && !reject),
        .open_row_in (req_addr[ADDR_W-1:COL_W]),
        .open_valid  (open_valid),
        .open_row    (open_row)
    );

    olm_byte_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) store_i (
        .clk   (clk),
        .we    (store_we),
        .waddr (addr_q),
        .wdata (wdata_q),
        .raddr (store_raddr),
        .rdata (store_rdata)
    );

    assign accept = (state == ST_IDLE) && req_valid;

    // State register and captured request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wait_cnt <= '0;
            left_cnt <= '0;
            ptr      <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            len_q    <= '0;
            write_q  <= 1'b0;
            burst_q  <= 1'b0;
        end else begin
            state    <= state_n;
            wait_cnt <= wait_n;
            left_cnt <= left_n;
            ptr      <= ptr_n;
            addr_q   <= addr_n;
            wdata_q  <= wdata_n;
            len_q    <= len_n;
            write_q  <= write_n;
            burst_q  <= burst_n;
        end
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        wait_n  = wait_cnt;
        left_n  = left_cnt;
        ptr_n   = ptr;
        addr_n  = addr_q;
        wdata_n = wdata_q;
        len_n   = len_q;
        write_n = write_q;
        burst_n = burst_q;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    addr_n  = req_addr;
                    wdata_n = req_wdata;
                    len_n   = req_len;
                    write_n = req_write;
                    burst_n = req_burst;
                    wait_n  = wait_load;
                    state_n = reject ? ST_REJECT : ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (wait_cnt != '0) begin
                    wait_n = wait_cnt - 1'b1;
                end else if (burst_q) begin
                    state_n = ST_STREAM;
                    ptr_n   = addr_q;
                    left_n  = len_q;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_STREAM: begin
                if (left_cnt == '0) begin
                    state_n = ST_IDLE;
                end else begin
                    left_n = left_cnt - 1'b1;
                    ptr_n  = ptr + 1'b1;
                end
            end
            ST_REJECT: begin
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        rsp_err     = (state == ST_REJECT);
        store_we    = 1'b0;
        rsp_valid   = 1'b0;
        store_raddr = addr_q;
        unique case (state)
            ST_ACCESS: begin
                if (wait_cnt == '0 && !burst_q) begin
                    store_we  = write_q;
                    rsp_valid = !write_q;
                end
            end
            ST_STREAM: begin
                rsp_valid   = 1'b1;
                store_raddr = ptr;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
        rsp_data = rsp_valid ? store_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cycles <= '0;
        end else if (state != ST_IDLE) begin
            busy_cycles <= busy_cycles + 1'b1;
        end
    end

    // R10: counter steps by one on each busy cycle, holds when idle
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> (busy_cycles == $past(busy_cycles) + 1'b1));
    a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> (busy_cycles == $past(busy_cycles)));

    // R6: a refusal lasts one cycle and carries no data
    a_r6_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> (req_ready && !rsp_err));
    a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_valid);

    // R5: streamed bytes come from consecutive addresses
    a_r5_stream_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && left_cnt != '0) |=>
            (state == ST_STREAM && ptr == $past(ptr) + 1'b1));

    // R9: nothing is accepted while busy, so the captured request is held
    a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && state != ST_REJECT) |=> (addr_q == $past(addr_q) && write_q == $past(write_q)));

endmodule

// File: tb/olm_open_row_mem_tb.sv
module olm_open_row_mem_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic        req_burst;
    logic [10:0] req_addr;
    logic [7:0]  req_len;
    logic [7:0]  req_wdata;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_err;
    logic [31:0] busy_cycles;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0] shadow [2048];
    bit         known  [2048];
    bit         m_open_valid = 1'b0;
    int         m_open_row   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    olm_open_row_mem dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_burst   (req_burst),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_err     (rsp_err),
        .busy_cycles (busy_cycles)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [7:0] pattern(input int a);
        return 8'((a & 255) ^ ((a >> 8) * 37) ^ 8'h5A);
    endfunction

    // One request; all expectations come from the bench model.
    // junk=1 holds a write to jaddr on the inputs during the busy period.
    task automatic access(input bit wr, input bit bu, input int a, input int ln,
                          input logic [7:0] wd, input bit junk, input int jaddr);
        int         row = a >> 8;
        int         col = a & 255;
        int         n   = bu ? ln + 1 : 1;
        bit         rej = bu && (wr || (col + ln > 255));
        bit         hit = m_open_valid && (m_open_row == row);
        int         exp_l;
        int         exp_rsp;
        int         busy = 0;
        int         nrsp = 0;
        int         first = -1;
        bit         errseen = 1'b0;
        int         bad = 0;
        logic [31:0] c0;
        logic [7:0] got [256];
        string      tag;

        if (rej)      begin exp_l = 1;      tag = wr ? "R7" : "R6"; end
        else if (bu)  begin exp_l = 10 + n; tag = "R5"; end
        else if (hit) begin exp_l = 3;      tag = "R3"; end
        else          begin exp_l = 10;     tag = "R2"; end
        exp_rsp = rej ? 0 : (bu ? n : (wr ? 0 : 1));

        c0        = busy_cycles;
        req_write = wr;
        req_burst = bu;
        req_addr  = 11'(a);
        req_len   = 8'(ln);
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        if (junk) begin
            req_write = 1'b1;
            req_burst = 1'b0;
            req_addr  = 11'(jaddr);
            req_wdata = ~shadow[jaddr];
        end else begin
            req_valid = 1'b0;
        end
        while (!req_ready && busy < 400) begin
            if (rsp_valid) begin
                if (first < 0) first = busy;
                if (nrsp < 256) got[nrsp] = rsp_data;
                nrsp++;
            end
            if (rsp_err) errseen = 1'b1;
            busy++;
            @(negedge clk);
        end
        req_valid = 1'b0;

        check(busy == exp_l, tag, "busy cycles", busy, exp_l);
        check(busy_cycles - c0 == 32'(exp_l), "R10", "counter delta", busy_cycles - c0, exp_l);
        check(errseen == rej, tag, "error flag", errseen, rej);
        check(nrsp == exp_rsp, bu ? "R5" : "R8", "response count", nrsp, exp_rsp);
        if (exp_rsp > 0) begin
            check(first == exp_l - exp_rsp, bu ? "R5" : "R8", "first data cycle", first, exp_l - exp_rsp);
            for (int i = 0; i < nrsp && i < n; i++) begin
                if (known[a + i] && got[i] !== shadow[a + i]) begin
                    if (bad == 0)
                        $display("FAIL %s data at 0x%0h: actual %0d expected %0d",
                                 bu ? "R5" : "R8", a + i, got[i], shadow[a + i]);
                    bad++;
                end
            end
            n_checks++;
            if (bad != 0) n_fail++;
        end

        if (!rej) begin
            m_open_valid = 1'b1;
            m_open_row   = row;
            if (wr && !bu) begin
                shadow[a] = wd;
                known[a]  = 1'b1;
            end
        end
    endtask

    task automatic single(input bit wr, input int a, input logic [7:0] wd);
        access(wr, 1'b0, a, 0, wd, 1'b0, 0);
    endtask

    task automatic burst(input bit wr, input int a, input int ln);
        access(wr, 1'b1, a, ln, 8'h00, 1'b0, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles at most", WATCHDOG, WATCHDOG - 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            shadow[i] = 8'h00;
            known[i]  = 1'b0;
        end
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_burst = 1'b0;
        req_addr  = '0;
        req_len   = '0;
        req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        check(rsp_err == 1'b0, "R1", "rsp_err after reset", rsp_err, 0);
        check(busy_cycles == 32'd0, "R1", "counter after reset", busy_cycles, 0);

        // R1/R2: first access is a miss even to row 0
        single(1'b1, 0, pattern(0));

        // Preload rows 0..3 (R3 hits within each row).
        for (int a = 1; a < 1024; a++) single(1'b1, a, pattern(a));

        // R4: column 255 and column 0 share row 0; 0x100 is row 1
        single(1'b0, 16'h000, 8'h00);
        single(1'b0, 16'h0FF, 8'h00);
        check(m_open_row == 0, "R4", "model row", m_open_row, 0);
        single(1'b0, 16'h100, 8'h00);

        // R5: shortest burst, full-row burst, burst ending on column 255
        burst(1'b0, 16'h105, 0);
        burst(1'b0, 16'h200, 255);
        burst(1'b0, 16'h3F0, 15);

        // R6: one byte past the row end is refused; open row stays row 3 (hit)
        burst(1'b0, 16'h0F0, 16);
        single(1'b0, 16'h301, 8'h00);

        // R7: write burst refused; open row still row 3
        burst(1'b1, 16'h310, 3);
        single(1'b0, 16'h302, 8'h00);

        // R11: burst opens row 1, following single hits
        burst(1'b0, 16'h120, 7);
        single(1'b0, 16'h1FE, 8'h00);

        // R9: a write held on the inputs while busy must be ignored
        access(1'b0, 1'b0, 16'h210, 0, 8'h00, 1'b1, 16'h020);
        single(1'b0, 16'h020, 8'h00);

        // R8: overwrite then read back
        single(1'b1, 16'h0AA, 8'hC3);
        single(1'b0, 16'h0AA, 8'h00);

        // Constrained random traffic over rows 0..3
        void'($urandom(32'd20240517));
        for (int k = 0; k < 400; k++) begin
            int  row = int'($urandom % 4);
            int  col = int'($urandom % 256);
            bit  bu  = ($urandom % 4) == 0;
            bit  wr  = bu ? (($urandom % 16) == 0) : bit'($urandom % 2);
            int  ln  = bu ? int'($urandom % 48) : 0;
            if (bu && ($urandom % 3) == 0) col = 255 - ln + int'($urandom % 3);
            if (col > 255) col = 255;
            access(wr, bu, row * 256 + col, ln, 8'($urandom), 1'b0, 0);
        end

        finish_run();
    end

endmodule